// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two binary floating-point operands in the 32-bit single format. Each operand has a sign bit at the top, an 8-bit exponent held with a bias of 127 below it, and a 23-bit fraction in the low bits with an implied leading one. The caller presents both operands, an operation bit, a two-bit rounding mode and a valid strobe. The result comes out with its own valid strobe, two clock cycles later by default. A new operation can be started in every cycle.

Inside, the second operand's sign is flipped for a subtract. The two operands are then ordered by magnitude, so the larger one leads. The smaller mantissa is shifted right by the exponent difference, and three extra bits (guard, round and a sticky OR of everything shifted further) are kept. The two mantissas are added or subtracted as sign and magnitude. The sum is renormalized, by one place right after a carry or by any number of places left after cancellation. Rounding is applied only after that, in the selected mode.

Some cases are simplified. Subnormal inputs and subnormal results are flushed to zero. Overflow gives an infinity. Any invalid case gives one canonical quiet NaN. The widths and the optional middle pipeline register are parameters. The defaults give the single format with two cycles of latency.

Top module: `fpadd_unit`

## Requirements
- R1: With rounding mode 0 (nearest, ties to even), in_sub = 0 returns the correctly rounded sum of in_a and in_b. Operands are encoded as sign at bit 31, exponent field in bits 30:23 with bias 127, and fraction in bits 22:0 (1.0 = 3F800000).
- R2: in_sub = 1 returns in_a minus in_b. This is exactly the sum of in_a and in_b with the sign of in_b inverted.
- R3: Operand order does not change a sum. When the exponents differ by more than the mantissa width, the smaller operand still contributes a sticky bit that directed rounding observes.
- R4: When the effective signs differ, the smaller magnitude is subtracted from the larger and the result takes the sign of the larger. A result that loses leading bits is shifted left and its exponent reduced to match.
- R5: A mantissa sum of 2.0 or more is shifted right one place and the exponent is raised by one.
- R6: In mode 0, a result exactly halfway between two representable values rounds to the one with an even last fraction bit. A result above the halfway point rounds away from the truncated value.
- R7: Mode 1 truncates toward zero. Mode 2 rounds toward plus infinity. Mode 3 rounds toward minus infinity.
- R8: A rounding increment that carries out of the fraction gives fraction 0 and an exponent raised by one.
- R9: A result whose exponent reaches 255 after rounding is returned as infinity with the result's sign (7F800000 or FF800000).
- R10: Any NaN input (exponent 255, fraction non-zero), or infinities of opposite effective sign, gives 7FC00000. Otherwise an infinite input returns that infinity with its effective sign.
- R11: An input with exponent field 0 is treated as zero. A finite result whose biased exponent would fall to 0 or below is returned as zero with the result's sign.
- R12: An exact zero from operands of opposite effective sign is +0 in modes 0 to 2 and -0 in mode 3. The sum of two zeros of the same effective sign keeps that sign.
- R13: out_valid is high exactly two cycles after each cycle in which in_valid was high (one cycle with MID_REG = 0). Back-to-back operations are accepted. Reset clears out_valid and out_result to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| in_sub | input | 1 | 0 adds, 1 subtracts in_b from in_a |
| in_rm | input | 2 | Rounding mode: 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | out_result holds a new result |
| out_result | output | 32 | Rounded result |

## Verification
The bench targets the corners where a floating-point adder usually goes wrong:

- **Exact ties.** A design that rounds half up, instead of to even, returns 3F800001 for 1.0 plus 2^-24.
- **Rounding carry.** A design that drops the carry from rounding into the exponent returns a fraction of zero with the old exponent.
- **Sticky bit.** A design that loses the sticky bit when the shift exceeds the datapath width ignores 2^-100 in the round-up mode.
- **Borrow during subtraction.** If the sticky borrow is lost, 1.0 minus 2^-30 truncates to 1.0 instead of 3F7FFFFF.
- **Zero and special values.** The bench covers the sign rules for exact zero, flushing of subnormals, overflow to infinity, and collapsing of NaN payloads. Swapping the operands must never change a sum.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

   typedef enum logic [1:0] {
      RM_NEAREST = 2'd0,
      RM_ZERO    = 2'd1,
      RM_UP      = 2'd2,
      RM_DOWN    = 2'd3
   } rmode_e;

endpackage

// File: rtl/fpadd_align.sv
module fpadd_align #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int W     = 1 + EXP_W + FRAC_W,
   localparam int MW    = FRAC_W + 1,
   localparam int XW    = MW + 3
) (
   input  logic [W-1:0]     opa,
   input  logic [W-1:0]     opb,
   input  logic             sub,
   output logic             big_sign,
   output logic             same_sign,
   output logic [EXP_W-1:0] big_exp,
   output logic [XW-1:0]    big_m,
   output logic [XW-1:0]    small_m,
   output logic             is_special,
   output logic [W-1:0]     special_val
);
   localparam logic [EXP_W-1:0] EXP_ONES = '1;
   localparam logic [W-1:0] QNAN = {1'b0, EXP_ONES, 1'b1, {(FRAC_W-1){1'b0}}};

   logic              sa, sb, a_nan, b_nan, a_inf, b_inf, swap;
   logic [EXP_W-1:0]  ea, eb, small_exp, ediff;
   logic [FRAC_W-1:0] fa, fb;
   logic [MW-1:0]     ma, mb, small_mm;
   logic [2*XW-1:0]   wide;
   int                shamt;

   always_comb begin
      sa = opa[W-1];
      sb = opb[W-1] ^ sub;
      ea = opa[W-2 -: EXP_W];
      eb = opb[W-2 -: EXP_W];
      fa = opa[FRAC_W-1:0];
      fb = opb[FRAC_W-1:0];
      a_nan = (ea == EXP_ONES) && (fa != '0);
      b_nan = (eb == EXP_ONES) && (fb != '0);
      a_inf = (ea == EXP_ONES) && (fa == '0);
      b_inf = (eb == EXP_ONES) && (fb == '0);
      // exponent field 0 means zero here (subnormals flushed)
      ma = (ea == '0) ? '0 : {1'b1, fa};
      mb = (eb == '0) ? '0 : {1'b1, fb};

      swap      = {eb, fb} > {ea, fa};
      big_sign  = swap ? sb : sa;
      same_sign = (sa == sb);
      big_exp   = swap ? eb : ea;
      small_exp = swap ? ea : eb;
      big_m     = {(swap ? mb : ma), 3'b000};
      small_mm  = swap ? ma : mb;
      ediff     = big_exp - small_exp;

      shamt = (int'(ediff) > XW) ? XW : int'(ediff);
      wide  = {small_mm, 3'b000, {XW{1'b0}}} >> shamt;
      small_m = wide[2*XW-1:XW] | {{(XW-1){1'b0}}, |wide[XW-1:0]};

      is_special  = a_nan | b_nan | a_inf | b_inf;
      if (a_nan || b_nan || (a_inf && b_inf && (sa != sb)))
         special_val = QNAN;
      else if (a_inf)
         special_val = {sa, EXP_ONES, {FRAC_W{1'b0}}};
      else
         special_val = {sb, EXP_ONES, {FRAC_W{1'b0}}};
   end

endmodule

// File: rtl/fpadd_round.sv
module fpadd_round
   import fpadd_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int W     = 1 + EXP_W + FRAC_W,
   localparam int MW    = FRAC_W + 1,
   localparam int XW    = MW + 3,
   localparam int LZ_W  = $clog2(XW + 1),
   localparam int EMAX  = (1 << EXP_W) - 1
) (
   input  logic             big_sign,
   input  logic             same_sign,
   input  logic [EXP_W-1:0] big_exp,
   input  logic [XW-1:0]    big_m,
   input  logic [XW-1:0]    small_m,
   input  logic [1:0]       rm,
   input  logic             is_special,
   input  logic [W-1:0]     special_val,
   output logic [W-1:0]     result
);
   logic [XW:0]     sum;
   logic [XW-1:0]   norm;
   logic [LZ_W-1:0] lz;
   logic [MW:0]     mant;
   logic            lsb, grd, rest, inc;
   int              e;
   rmode_e          mode;

   always_comb begin
      mode = rmode_e'(rm);
      sum  = same_sign ? ({1'b0, big_m} + {1'b0, small_m})
                       : ({1'b0, big_m} - {1'b0, small_m});
      lz = '0;
      for (int i = 0; i < XW; i++)
         if (sum[i]) lz = LZ_W'(XW - 1 - i);

      if (sum[XW]) begin
         norm = {sum[XW:2], sum[1] | sum[0]};
         e    = int'(big_exp) + 1;
      end else begin
         norm = sum[XW-1:0] << lz;
         e    = int'(big_exp) - int'(lz);
      end

      lsb  = norm[3];
      grd  = norm[2];
      rest = norm[1] | norm[0];
      unique case (mode)
         RM_NEAREST: inc = grd & (rest | lsb);
         RM_ZERO:    inc = 1'b0;
         RM_UP:      inc = ~big_sign & (grd | rest);
         RM_DOWN:    inc = big_sign & (grd | rest);
         default:    inc = 1'b0;
      endcase
      mant = {1'b0, norm[XW-1:3]} + {{MW{1'b0}}, inc};
      if (mant[MW]) e = e + 1;

      if (is_special)
         result = special_val;
      else if (sum == '0)
         result = {(same_sign ? big_sign : (mode == RM_DOWN)), {(W-1){1'b0}}};
      else if (e <= 0)
         result = {big_sign, {(W-1){1'b0}}};
      else if (e >= EMAX)
         result = {big_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      else
         result = {big_sign, EXP_W'(e), (mant[MW] ? {FRAC_W{1'b0}} : mant[FRAC_W-1:0])};
   end

endmodule

// File: rtl/fpadd_unit.sv
module fpadd_unit #(
   parameter int EXP_W   = 8,
   parameter int FRAC_W  = 23,
   parameter bit MID_REG = 1'b1,
   localparam int W      = 1 + EXP_W + FRAC_W,
   localparam int XW     = FRAC_W + 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic         in_sub,
   input  logic [1:0]   in_rm,
   input  logic [W-1:0] in_a,
   input  logic [W-1:0] in_b,
   output logic         out_valid,
   output logic [W-1:0] out_result
);
   localparam int BW = 1 + 2 + 1 + 1 + EXP_W + XW + XW + 1 + W;

   generate
      if (EXP_W < 3 || EXP_W > 15) begin : g_bad_exp
         $error("fpadd_unit: EXP_W out of range");
      end
      if (FRAC_W < 2 || FRAC_W > 60) begin : g_bad_frac
         $error("fpadd_unit: FRAC_W out of range");
      end
   endgenerate

   logic             a_bsign, a_same, a_spec;
   logic [EXP_W-1:0] a_bexp;
   logic [XW-1:0]    a_bm, a_sm;
   logic [W-1:0]     a_sval;
   logic [BW-1:0]    stg_d, stg_q;
   logic             r_bsign, r_same, r_spec, r_valid;
   logic [1:0]       r_rm;
   logic [EXP_W-1:0] r_bexp;
   logic [XW-1:0]    r_bm, r_sm;
   logic [W-1:0]     r_sval, r_result;

   fpadd_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
      .opa(in_a), .opb(in_b), .sub(in_sub),
      .big_sign(a_bsign), .same_sign(a_same), .big_exp(a_bexp),
      .big_m(a_bm), .small_m(a_sm),
      .is_special(a_spec), .special_val(a_sval)
   );

   assign stg_d = {in_valid, in_rm, a_bsign, a_same, a_bexp, a_bm, a_sm, a_spec, a_sval};

   generate
      if (MID_REG) begin : g_mid_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q <= '0;
            else        stg_q <= stg_d;
         end
      end else begin : g_mid_wire
         assign stg_q = stg_d;
      end
   endgenerate

   assign {r_valid, r_rm, r_bsign, r_same, r_bexp, r_bm, r_sm, r_spec, r_sval} = stg_q;

   fpadd_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
      .big_sign(r_bsign), .same_sign(r_same), .big_exp(r_bexp),
      .big_m(r_bm), .small_m(r_sm), .rm(r_rm),
      .is_special(r_spec), .special_val(r_sval), .result(r_result)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_result <= '0;
      end else begin
         out_valid <= r_valid;
         if (r_valid) out_result <= r_result;
      end
   end

endmodule

// File: rtl/fpadd_checker.sv
module fpadd_checker #(
   parameter int EXP_W   = 8,
   parameter int FRAC_W  = 23,
   parameter bit MID_REG = 1'b1,
   localparam int W      = 1 + EXP_W + FRAC_W,
   localparam int LAT    = MID_REG ? 2 : 1
) (
   input logic         clk,
   input logic         rst_n,
   input logic         in_valid,
   input logic         in_sub,
   input logic [1:0]   in_rm,
   input logic [W-1:0] in_a,
   input logic [W-1:0] in_b,
   input logic         out_valid,
   input logic [W-1:0] out_result
);
   localparam logic [EXP_W-1:0] ONES = '1;
   localparam logic [W-1:0] QNAN = {1'b0, ONES, 1'b1, {(FRAC_W-1){1'b0}}};

   logic [LAT-1:0]    vq, nq, cq;
   logic [EXP_W-1:0]  oe;
   logic [FRAC_W-1:0] of;
   logic              a_nan, cancel;

   assign oe     = out_result[W-2 -: EXP_W];
   assign of     = out_result[FRAC_W-1:0];
   assign a_nan  = (in_a[W-2 -: EXP_W] == ONES) && (in_a[FRAC_W-1:0] != '0);
   assign cancel = in_sub && (in_a == in_b) && (in_a[W-2 -: EXP_W] != ONES) && (in_rm != 2'd3);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vq <= '0; nq <= '0; cq <= '0;
      end else begin
         vq[0] <= in_valid;
         nq[0] <= in_valid & a_nan;
         cq[0] <= in_valid & cancel;
         for (int i = 1; i < LAT; i++) begin
            vq[i] <= vq[i-1];
            nq[i] <= nq[i-1];
            cq[i] <= cq[i-1];
         end
      end
   end

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) out_valid == vq[LAT-1]); // R13
   AST_NAN_CANONICAL: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && oe == ONES && of != '0) |-> out_result == QNAN); // R10
   AST_NAN_INPUT: assert property (@(posedge clk) disable iff (!rst_n) nq[LAT-1] |-> out_result == QNAN); // R10
   AST_NO_SUBNORMAL: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> !(oe == '0 && of != '0)); // R11
   AST_SELF_CANCEL: assert property (@(posedge clk) disable iff (!rst_n) cq[LAT-1] |-> out_result == '0); // R12

endmodule

bind fpadd_unit fpadd_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .MID_REG(MID_REG)) u_fpadd_checker (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sub(in_sub), .in_rm(in_rm),
   .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result)
);

// File: tb/test_fpadd_unit.sv
`timescale 1ns/1ps
module test_fpadd_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_sub = 1'b0;
   logic [1:0]  in_rm = 2'd0;
   logic [31:0] in_a = '0;
   logic [31:0] in_b = '0;
   logic        out_valid;
   logic [31:0] out_result;
   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   fpadd_unit i_fpadd_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sub(in_sub), .in_rm(in_rm),
      .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result)
   );

   // {tag, a, b, sub, rm, expected}
   localparam int NV = 38;
   localparam logic [122:0] VEC [NV] = '{
      {"R1 ", 32'h3F800000, 32'h3F800000, 1'b0, 2'd0, 32'h40000000},
      {"R1 ", 32'h3FC00000, 32'h40200000, 1'b0, 2'd0, 32'h40800000},
      {"R1 ", 32'h3E4CCCCD, 32'h3E4CCCCD, 1'b0, 2'd0, 32'h3ECCCCCD},
      {"R2 ", 32'h3F800000, 32'h40000000, 1'b1, 2'd0, 32'hBF800000},
      {"R2 ", 32'h40000000, 32'hBF800000, 1'b1, 2'd0, 32'h40400000},
      {"R4 ", 32'h3FC00000, 32'h3FA00000, 1'b1, 2'd0, 32'h3E800000},
      {"R4 ", 32'h3F800001, 32'h3F800000, 1'b1, 2'd0, 32'h34000000},
      {"R4 ", 32'h3F800000, 32'hC0000000, 1'b0, 2'd0, 32'hBF800000},
      {"R5 ", 32'h3FC00000, 32'h3FC00000, 1'b0, 2'd0, 32'h40400000},
      {"R3 ", 32'h4B800000, 32'h3F800000, 1'b0, 2'd0, 32'h4B800000},
      {"R3 ", 32'h3F800000, 32'h4B800000, 1'b0, 2'd0, 32'h4B800000},
      {"R3 ", 32'h3F800000, 32'h0D800000, 1'b0, 2'd2, 32'h3F800001},
      {"R3 ", 32'h3F800000, 32'h0D800000, 1'b0, 2'd0, 32'h3F800000},
      {"R6 ", 32'h3F800000, 32'h33800000, 1'b0, 2'd0, 32'h3F800000},
      {"R6 ", 32'h3F800001, 32'h33800000, 1'b0, 2'd0, 32'h3F800002},
      {"R6 ", 32'h3F800000, 32'h33C00000, 1'b0, 2'd0, 32'h3F800001},
      {"R6 ", 32'h3F800000, 32'h30800000, 1'b1, 2'd0, 32'h3F800000},
      {"R7 ", 32'h3F800000, 32'h33800000, 1'b0, 2'd1, 32'h3F800000},
      {"R7 ", 32'h3F800000, 32'h33800000, 1'b0, 2'd2, 32'h3F800001},
      {"R7 ", 32'hBF800000, 32'hB3800000, 1'b0, 2'd3, 32'hBF800001},
      {"R7 ", 32'hBF800000, 32'hB3800000, 1'b0, 2'd2, 32'hBF800000},
      {"R7 ", 32'h3F800000, 32'h30800000, 1'b1, 2'd1, 32'h3F7FFFFF},
      {"R8 ", 32'h3FFFFFFF, 32'h33800000, 1'b0, 2'd0, 32'h40000000},
      {"R9 ", 32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 2'd0, 32'h7F800000},
      {"R9 ", 32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 2'd0, 32'hFF800000},
      {"R10", 32'h7FC00001, 32'h3F800000, 1'b0, 2'd0, 32'h7FC00000},
      {"R10", 32'h3F800000, 32'hFF800001, 1'b0, 2'd0, 32'h7FC00000},
      {"R10", 32'h7F800000, 32'hFF800000, 1'b0, 2'd0, 32'h7FC00000},
      {"R10", 32'h7F800000, 32'h7F800000, 1'b1, 2'd0, 32'h7FC00000},
      {"R10", 32'h7F800000, 32'h3F800000, 1'b0, 2'd0, 32'h7F800000},
      {"R10", 32'h3F800000, 32'h7F800000, 1'b1, 2'd0, 32'hFF800000},
      {"R11", 32'h00000001, 32'h3F800000, 1'b0, 2'd0, 32'h3F800000},
      {"R11", 32'h00C00000, 32'h00800000, 1'b1, 2'd0, 32'h00000000},
      {"R11", 32'h007FFFFF, 32'h007FFFFF, 1'b0, 2'd0, 32'h00000000},
      {"R12", 32'h3F800000, 32'h3F800000, 1'b1, 2'd0, 32'h00000000},
      {"R12", 32'h3F800000, 32'h3F800000, 1'b1, 2'd3, 32'h80000000},
      {"R12", 32'h80000000, 32'h80000000, 1'b0, 2'd0, 32'h80000000},
      {"R12", 32'hC0000000, 32'hC0000000, 1'b1, 2'd2, 32'h00000000}
   };

   task automatic check(input logic [23:0] tag, input logic [31:0] act, input logic [31:0] exp_v);
      checks++;
      if (act !== exp_v) begin
         errors++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp_v);
      end
   endtask

   task automatic run_op(input logic [23:0] tag, input logic [31:0] a, input logic [31:0] b,
                         input logic sub, input logic [1:0] rm, input logic [31:0] exp_v);
      @(negedge clk);
      in_a = a; in_b = b; in_sub = sub; in_rm = rm; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R13", {31'd0, out_valid}, 32'd0);
      @(negedge clk);
      check("R13", {31'd0, out_valid}, 32'd1);
      check(tag, out_result, exp_v);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R13: reset state
      check("R13", {31'd0, out_valid}, 32'd0);
      check("R13", out_result, 32'h0);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++)
         run_op(VEC[i][122:99], VEC[i][98:67], VEC[i][66:35], VEC[i][34], VEC[i][33:32], VEC[i][31:0]);

      // R13: back-to-back issue, results in consecutive cycles
      @(negedge clk);
      in_a = 32'h3F800000; in_b = 32'h3F800000; in_sub = 1'b0; in_rm = 2'd0; in_valid = 1'b1;
      @(negedge clk);
      in_a = 32'h40400000; in_b = 32'h3F800000; in_sub = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R13", {31'd0, out_valid}, 32'd1);
      check("R1 ", out_result, 32'h40000000);
      @(negedge clk);
      check("R13", {31'd0, out_valid}, 32'd1);
      check("R2 ", out_result, 32'h40000000);
      @(negedge clk);
      check("R13", {31'd0, out_valid}, 32'd0);

      // R13: reset mid-stream clears outputs
      rst_n = 1'b0;
      @(negedge clk);
      check("R13", out_result, 32'h0);
      check("R13", {31'd0, out_valid}, 32'd0);
      rst_n = 1'b1;

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule